// File: doc/BRIEF.md
# Precise-Exception Dispatch Interlock

This block sits between instruction decode and two execution pipelines, one fixed-point and one floating-point. Each cycle it may be offered a group of up to four decoded instructions, each classified as fixed-point arithmetic, integer load/store, floating-point load/store or floating-point arithmetic, and each carrying a 4-bit sequence tag and a flag saying it may raise an exception. It places the instructions, oldest first, into two 4-entry queues that feed the units. Every memory access, including floating-point loads and stores, goes to the fixed-point queue.

Exceptions stay precise without a reorder buffer. A fixed-point-side instruction that may fault opens a pending check. Until the fixed-point side returns a matching resolve, no floating-point arithmetic instruction is released. Only one check may be open at a time. A resolve that reports an exception flushes the fixed-point queue and the undispatched rest of the held group in the same cycle, and presents the faulting tag. Anything already in the floating-point queue is older than the faulting instruction, so the floating-point queue is kept.

Top module: `exc_dispatch_ilock`

## Requirements
- R1: While rst_ni is low, both queues are emptied and the pending check is cleared. After release, fx_valid_o and fp_valid_o are 0, flush_o is 0, and a lone floating-point arithmetic instruction is accepted in its first cycle.
- R2: The kind field is 2 bits per slot, with slot i at grp_kind_i[2i+1:2i]. Codes 00 (fixed-point arithmetic), 01 (integer load/store) and 10 (floating-point load/store) go to the fixed-point queue. Code 11 (floating-point arithmetic) goes to the floating-point queue. Slot i's tag is at grp_tag_i[4i+3:4i].
- R3: At most one instruction enters the fixed-point queue per cycle, whether it is arithmetic or a load/store. At most one enters the floating-point queue per cycle. With no check pending, one of each may enter in the same cycle.
- R4: Slots are taken in ascending index order, and slot 0 is the oldest. Slots whose grp_slot_vld_i bit is 0 are skipped. A slot that cannot be placed holds back every higher slot. grp_ready_o is high in the cycle in which all remaining valid slots are placed, and the group is then consumed at that edge.
- R5: Each queue holds 4 entries. When the queue an instruction needs is full, that instruction waits. Entries leave each queue in arrival order, and an entry stays on the outputs until its ready is high.
- R6: A fixed-point-side instruction with its may-except bit at 1 opens a pending check when it is dispatched. Floating-point arithmetic is held while the check is pending, and so is a younger floating-point arithmetic instruction in the same cycle. Older ones proceed. Floating-point dispatch resumes in the cycle after the matching resolve.
- R7: Only one check may be pending. A second may-except fixed-point-side instruction waits until the first resolves, while fixed-point instructions without the flag still proceed.
- R8: A resolve whose tag equals the pending tag closes the check. A resolve with no check pending, or with a different tag, has no effect: flush_o stays 0 and the check stays pending.
- R9: A matching resolve with res_exc_i at 1 has these effects in the same cycle: flush_o goes high, fault_tag_o carries the tag, grp_ready_o goes high and nothing is dispatched. At that edge the fixed-point queue is emptied and the check is closed, while the floating-point queue keeps its entries.
- R10: The may-except bit of a floating-point arithmetic instruction is ignored and opens no check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp_valid_i | input | 1 | A fetch group is offered |
| grp_ready_o | output | 1 | Group fully placed or discarded this cycle |
| grp_slot_vld_i | input | 4 | Per-slot valid |
| grp_kind_i | input | 8 | Per-slot kind code, 2 bits each |
| grp_mayexc_i | input | 4 | Per-slot may-except flag |
| grp_tag_i | input | 16 | Per-slot sequence tag, 4 bits each |
| fx_valid_o | output | 1 | Fixed-point queue head valid |
| fx_ready_i | input | 1 | Fixed-point unit accepts head |
| fx_tag_o | output | 4 | Head tag |
| fx_kind_o | output | 2 | Head kind code |
| fx_mayexc_o | output | 1 | Head may-except flag |
| fp_valid_o | output | 1 | Floating-point queue head valid |
| fp_ready_i | input | 1 | Floating-point unit accepts head |
| fp_tag_o | output | 4 | Head tag |
| res_valid_i | input | 1 | Resolve strobe from fixed-point side |
| res_tag_i | input | 4 | Tag being resolved |
| res_exc_i | input | 1 | Resolved instruction faulted |
| flush_o | output | 1 | Flush of younger work this cycle |
| fault_tag_o | output | 4 | Faulting tag while flush_o is high, else 0 |

## Verification
A faulting resolve can arrive in the same cycle as dispatch of a held group that has fixed-point queue entries behind it and an older floating-point entry ahead of it. The bench sets this up by dispatching a may-except instruction, draining only that instruction, queuing two younger fixed-point instructions, and leaving a blocked floating-point slot in the group. It then checks that the flush wins the cycle, with the group consumed, nothing placed and the right fault tag, and that on the next cycle only the floating-point entry remains. Exhaustive sweeps over all kind mixes and slot-valid patterns compare the cycles the group takes and the order each queue releases against a greedy count worked out in the bench.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [1:0] {
    K_FXA = 2'b00,
    K_ILS = 2'b01,
    K_FLS = 2'b10,
    K_FPA = 2'b11
  } kind_e;

  function automatic logic to_fx(input kind_e k);
    return k != K_FPA;
  endfunction
endpackage

// File: rtl/dq_fifo.sv
module dq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic          valid_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem[wp_q] <= din_i;
  end

  assign dout_o  = mem[rp_q];
  assign valid_o = cnt_q != '0;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/slot_scan.sv
module slot_scan import disp_pkg::*; #(
  parameter int SLOTS = 4,
  parameter int TAG_W = 4
) (
  input  logic [SLOTS-1:0]       rem_i,
  input  logic [2*SLOTS-1:0]     kind_i,
  input  logic [SLOTS-1:0]       mx_i,
  input  logic [TAG_W*SLOTS-1:0] tag_i,
  input  logic                   fx_full_i,
  input  logic                   fp_full_i,
  input  logic                   pend_i,
  output logic [SLOTS-1:0]       take_o,
  output logic                   fx_push_o,
  output logic [TAG_W-1:0]       fx_tag_o,
  output logic [1:0]             fx_kind_o,
  output logic                   fx_mx_o,
  output logic                   fp_push_o,
  output logic [TAG_W-1:0]       fp_tag_o,
  output logic                   exc_set_o,
  output logic [TAG_W-1:0]       exc_tag_o
);
  kind_e            kind_a [SLOTS];
  logic [TAG_W-1:0] tag_a  [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_unpack
    assign kind_a[g] = kind_e'(kind_i[2*g +: 2]);
    assign tag_a[g]  = tag_i[TAG_W*g +: TAG_W];
  end

  // greedy in-order pick: one lane each, first blocked slot stops the scan
  always_comb begin
    logic blk;
    blk       = 1'b0;
    take_o    = '0;
    fx_push_o = 1'b0;
    fx_tag_o  = '0;
    fx_kind_o = '0;
    fx_mx_o   = 1'b0;
    fp_push_o = 1'b0;
    fp_tag_o  = '0;
    exc_set_o = 1'b0;
    exc_tag_o = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (rem_i[i] && !blk) begin
        if (to_fx(kind_a[i])) begin
          if (fx_push_o || fx_full_i || (mx_i[i] && pend_i)) begin
            blk = 1'b1;
          end else begin
            take_o[i] = 1'b1;
            fx_push_o = 1'b1;
            fx_tag_o  = tag_a[i];
            fx_kind_o = kind_a[i];
            fx_mx_o   = mx_i[i];
            if (mx_i[i]) begin
              exc_set_o = 1'b1;
              exc_tag_o = tag_a[i];
            end
          end
        end else begin
          if (fp_push_o || fp_full_i || pend_i || exc_set_o) begin
            blk = 1'b1;
          end else begin
            take_o[i] = 1'b1;
            fp_push_o = 1'b1;
            fp_tag_o  = tag_a[i];
          end
        end
      end
    end
  end
endmodule

// File: rtl/pend_trk.sv
module pend_trk #(
  parameter int TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic             res_valid_i,
  input  logic [TAG_W-1:0] res_tag_i,
  input  logic             res_exc_i,
  output logic             pend_o,
  output logic             flush_o
);
  logic             pend_q;
  logic [TAG_W-1:0] tag_q;
  logic             hit;

  assign hit     = res_valid_i && pend_q && (res_tag_i == tag_q);
  assign flush_o = hit && res_exc_i;
  assign pend_o  = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      tag_q  <= '0;
    end else if (hit) begin
      pend_q <= 1'b0;
    end else if (set_i) begin
      pend_q <= 1'b1;
      tag_q  <= set_tag_i;
    end
  end
endmodule

// File: rtl/exc_dispatch_ilock.sv
module exc_dispatch_ilock import disp_pkg::*; #(
  parameter int SLOTS   = 4,
  parameter int TAG_W   = 4,
  parameter int Q_DEPTH = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   grp_valid_i,
  output logic                   grp_ready_o,
  input  logic [SLOTS-1:0]       grp_slot_vld_i,
  input  logic [2*SLOTS-1:0]     grp_kind_i,
  input  logic [SLOTS-1:0]       grp_mayexc_i,
  input  logic [TAG_W*SLOTS-1:0] grp_tag_i,
  output logic                   fx_valid_o,
  input  logic                   fx_ready_i,
  output logic [TAG_W-1:0]       fx_tag_o,
  output logic [1:0]             fx_kind_o,
  output logic                   fx_mayexc_o,
  output logic                   fp_valid_o,
  input  logic                   fp_ready_i,
  output logic [TAG_W-1:0]       fp_tag_o,
  input  logic                   res_valid_i,
  input  logic [TAG_W-1:0]       res_tag_i,
  input  logic                   res_exc_i,
  output logic                   flush_o,
  output logic [TAG_W-1:0]       fault_tag_o
);
  localparam int CW  = $clog2(Q_DEPTH + 1);
  localparam int FXW = TAG_W + 3;

  logic [SLOTS-1:0] done_q, rem, take;
  logic             flush, pend_q;
  logic             fx_push, fx_push_mx, fp_push, exc_set;
  logic [1:0]       fx_push_kind;
  logic [TAG_W-1:0] fx_push_tag, fp_push_tag, exc_tag;
  logic [CW-1:0]    fx_cnt, fp_cnt;
  logic             fx_full, fp_full, fx_q_valid;
  logic [FXW-1:0]   fx_dout;

  assign rem         = (grp_valid_i && !flush) ? (grp_slot_vld_i & ~done_q) : '0;
  assign grp_ready_o = flush || ((rem & ~take) == '0);
  assign fx_full     = fx_cnt == CW'(Q_DEPTH);
  assign fp_full     = fp_cnt == CW'(Q_DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         done_q <= '0;
    else if (grp_valid_i && !grp_ready_o) done_q <= done_q | take;
    else                                 done_q <= '0;
  end

  slot_scan #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_scan (
    .rem_i     (rem),
    .kind_i    (grp_kind_i),
    .mx_i      (grp_mayexc_i),
    .tag_i     (grp_tag_i),
    .fx_full_i (fx_full),
    .fp_full_i (fp_full),
    .pend_i    (pend_q),
    .take_o    (take),
    .fx_push_o (fx_push),
    .fx_tag_o  (fx_push_tag),
    .fx_kind_o (fx_push_kind),
    .fx_mx_o   (fx_push_mx),
    .fp_push_o (fp_push),
    .fp_tag_o  (fp_push_tag),
    .exc_set_o (exc_set),
    .exc_tag_o (exc_tag)
  );

  pend_trk #(.TAG_W(TAG_W)) u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (exc_set),
    .set_tag_i   (exc_tag),
    .res_valid_i (res_valid_i),
    .res_tag_i   (res_tag_i),
    .res_exc_i   (res_exc_i),
    .pend_o      (pend_q),
    .flush_o     (flush)
  );

  dq_fifo #(.W(FXW), .DEPTH(Q_DEPTH)) u_fxq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (flush),
    .push_i  (fx_push),
    .din_i   ({fx_push_tag, fx_push_kind, fx_push_mx}),
    .pop_i   (fx_valid_o && fx_ready_i),
    .dout_o  (fx_dout),
    .valid_o (fx_q_valid),
    .cnt_o   (fx_cnt)
  );

  dq_fifo #(.W(TAG_W), .DEPTH(Q_DEPTH)) u_fpq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (1'b0),
    .push_i  (fp_push),
    .din_i   (fp_push_tag),
    .pop_i   (fp_valid_o && fp_ready_i),
    .dout_o  (fp_tag_o),
    .valid_o (fp_valid_o),
    .cnt_o   (fp_cnt)
  );

  assign fx_valid_o  = fx_q_valid && !flush;
  assign fx_tag_o    = fx_dout[FXW-1 -: TAG_W];
  assign fx_kind_o   = fx_dout[2:1];
  assign fx_mayexc_o = fx_dout[0];
  assign flush_o     = flush;
  assign fault_tag_o = flush ? res_tag_i : '0;
endmodule

// File: rtl/exc_dispatch_ilock_chk.sv
module exc_dispatch_ilock_chk #(
  parameter int Q_DEPTH = 4,
  parameter int TAG_W   = 4,
  localparam int CW     = $clog2(Q_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_o,
  input logic             grp_ready_o,
  input logic             fx_valid_o,
  input logic             fx_ready_i,
  input logic [TAG_W-1:0] fx_tag_o,
  input logic             fp_valid_o,
  input logic             fp_ready_i,
  input logic [TAG_W-1:0] fp_tag_o,
  input logic             pend_q,
  input logic             fx_push,
  input logic             fx_push_mx,
  input logic             fp_push,
  input logic [CW-1:0]    fx_cnt,
  input logic [CW-1:0]    fp_cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fx_cnt <= CW'(Q_DEPTH)) && (fp_cnt <= CW'(Q_DEPTH))); // R5
  AST_FX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fx_valid_o && !fx_ready_i |=> flush_o || (fx_valid_o && $stable(fx_tag_o))); // R5
  AST_FP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_valid_o && !fp_ready_i |=> fp_valid_o && $stable(fp_tag_o)); // R5
  AST_FP_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !fp_push); // R6
  AST_ONE_CHECK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !(fx_push && fx_push_mx)); // R7
  AST_FLUSH_CONSUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> grp_ready_o && !fx_push && !fp_push); // R9
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !fx_valid_o && !pend_q); // R9
endmodule

bind exc_dispatch_ilock exc_dispatch_ilock_chk #(.Q_DEPTH(Q_DEPTH), .TAG_W(TAG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_o     (flush_o),
  .grp_ready_o (grp_ready_o),
  .fx_valid_o  (fx_valid_o),
  .fx_ready_i  (fx_ready_i),
  .fx_tag_o    (fx_tag_o),
  .fp_valid_o  (fp_valid_o),
  .fp_ready_i  (fp_ready_i),
  .fp_tag_o    (fp_tag_o),
  .pend_q      (pend_q),
  .fx_push     (fx_push),
  .fx_push_mx  (fx_push_mx),
  .fp_push     (fp_push),
  .fx_cnt      (fx_cnt),
  .fp_cnt      (fp_cnt)
);

// File: tb/sim_exc_dispatch_ilock.sv
module sim_exc_dispatch_ilock;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic grp_valid_i = 0, fx_ready_i = 0, fp_ready_i = 0;
  logic res_valid_i = 0, res_exc_i = 0;
  logic [3:0] grp_slot_vld_i = '0, grp_mayexc_i = '0, res_tag_i = '0;
  logic [7:0] grp_kind_i = '0;
  logic [15:0] grp_tag_i = '0;
  logic grp_ready_o, fx_valid_o, fx_mayexc_o, fp_valid_o, flush_o;
  logic [3:0] fx_tag_o, fp_tag_o, fault_tag_o;
  logic [1:0] fx_kind_o;

  int n_chk = 0, n_fail = 0;
  int fx_log [32];
  int fp_log [32];
  int fx_n = 0, fp_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_dispatch_ilock u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .grp_valid_i(grp_valid_i), .grp_ready_o(grp_ready_o),
    .grp_slot_vld_i(grp_slot_vld_i), .grp_kind_i(grp_kind_i),
    .grp_mayexc_i(grp_mayexc_i), .grp_tag_i(grp_tag_i),
    .fx_valid_o(fx_valid_o), .fx_ready_i(fx_ready_i), .fx_tag_o(fx_tag_o),
    .fx_kind_o(fx_kind_o), .fx_mayexc_o(fx_mayexc_o),
    .fp_valid_o(fp_valid_o), .fp_ready_i(fp_ready_i), .fp_tag_o(fp_tag_o),
    .res_valid_i(res_valid_i), .res_tag_i(res_tag_i), .res_exc_i(res_exc_i),
    .flush_o(flush_o), .fault_tag_o(fault_tag_o)
  );

  always @(posedge clk) begin
    if (rst_ni && fx_valid_o && fx_ready_i) begin
      if (fx_n < 32) fx_log[fx_n] = int'(fx_tag_o);
      fx_n++;
    end
    if (rst_ni && fp_valid_o && fp_ready_i) begin
      if (fp_n < 32) fp_log[fp_n] = int'(fp_tag_o);
      fp_n++;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not end, got 0 expected 1");
    summary();
    $finish;
  end

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_logs();
    fx_n = 0;
    fp_n = 0;
  endtask

  task automatic send_grp(input logic [3:0] vld, input logic [7:0] k, input logic [3:0] mx,
                          input logic [15:0] tags, input int maxc, output int cyc, output int ok);
    @(negedge clk);
    grp_valid_i = 1; grp_slot_vld_i = vld; grp_kind_i = k; grp_mayexc_i = mx; grp_tag_i = tags;
    #1;
    cyc = 1;
    while (!grp_ready_o && cyc < maxc) begin
      @(negedge clk); #1; cyc++;
    end
    ok = int'(grp_ready_o);
    if (ok == 1) begin
      @(negedge clk);
      grp_valid_i = 0;
    end
  endtask

  task automatic res_on(input logic [3:0] t, input logic e);
    @(negedge clk);
    res_valid_i = 1; res_tag_i = t; res_exc_i = e;
    #1;
  endtask

  task automatic res_off();
    @(negedge clk);
    res_valid_i = 0; res_exc_i = 0;
    #1;
  endtask

  function automatic int exp_cyc(input logic [3:0] vld, input logic [7:0] k);
    int c = 0;
    int i = 0;
    bit fx, fp, stop;
    while (i < 4 && !vld[i]) i++;
    while (i < 4) begin
      c++; fx = 0; fp = 0; stop = 0;
      while (i < 4 && !stop) begin
        if (!vld[i]) i++;
        else if (k[2*i +: 2] != 2'b11) begin
          if (fx) stop = 1; else begin fx = 1; i++; end
        end else begin
          if (fp) stop = 1; else begin fp = 1; i++; end
        end
      end
    end
    if (c == 0) c = 1;
    return c;
  endfunction

  task automatic sweep_one(input logic [3:0] vld, input logic [7:0] k);
    int cyc, ok, efx, efp, nfx, nfp, ofx, ofp;
    clr_logs();
    send_grp(vld, k, 4'b0000, 16'h4321, 8, cyc, ok);
    tk(6);
    efx = 0; efp = 0; nfx = 0; nfp = 0; ofx = 0; ofp = 0;
    for (int i = 0; i < 4; i++) begin
      if (vld[i] && k[2*i +: 2] != 2'b11) begin efx |= (i + 1) << (4 * nfx); nfx++; end
      if (vld[i] && k[2*i +: 2] == 2'b11) begin efp |= (i + 1) << (4 * nfp); nfp++; end
    end
    for (int j = 0; j < fx_n && j < 4; j++) ofx |= fx_log[j] << (4 * j);
    for (int j = 0; j < fp_n && j < 4; j++) ofp |= fp_log[j] << (4 * j);
    chk("R3/R4 cycles to place group", cyc, exp_cyc(vld, k));
    chk("R2/R5 fixed-point queue order", ofx | (fx_n << 16), efx | (nfx << 16));
    chk("R2/R5 floating-point queue order", ofp | (fp_n << 16), efp | (nfp << 16));
  endtask

  initial begin
    int cyc, ok;
    tk(3);
    rst_ni = 1;
    #1;
    // R1 reset state
    chk("R1 fx_valid after reset", int'(fx_valid_o), 0);
    chk("R1 fp_valid after reset", int'(fp_valid_o), 0);
    chk("R1 flush after reset", int'(flush_o), 0);

    // R5 full fixed-point queue blocks, then drains in order
    clr_logs();
    send_grp(4'hF, 8'h00, 4'h0, 16'h3210, 8, cyc, ok);
    chk("R3 four fixed-point slots take four cycles", cyc, 4);
    send_grp(4'h1, 8'h00, 4'h0, 16'h0004, 3, cyc, ok);
    chk("R5 full queue holds group", ok, 0);
    @(negedge clk); fx_ready_i = 1; #1;
    @(negedge clk); #1;
    chk("R5 space frees dispatch", int'(grp_ready_o), 1);
    @(negedge clk); grp_valid_i = 0;
    tk(6);
    chk("R5 drained count", fx_n, 5);
    for (int j = 0; j < 5; j++) chk("R5 drain order", fx_log[j], j);

    // sweeps R2 R3 R4
    fx_ready_i = 1; fp_ready_i = 1;
    for (int v = 0; v < 256; v++) sweep_one(4'hF, 8'(v));
    for (int v = 0; v < 16; v++) begin
      sweep_one(4'(v), 8'hCC);
      sweep_one(4'(v), 8'h00);
    end

    // R6 younger FP held behind may-except FX in same group
    clr_logs();
    send_grp(4'b0011, 8'h0C, 4'b0001, 16'h0065, 4, cyc, ok);
    chk("R6 younger fp held", ok, 0);
    chk("R6 no fp released", fp_n, 0);
    res_on(4'd5, 1'b0);
    chk("R8 clean resolve no flush", int'(flush_o), 0);
    res_off();
    chk("R6 fp resumes after resolve", int'(grp_ready_o), 1);
    @(negedge clk); grp_valid_i = 0;
    tk(3);
    chk("R6 fp released tag", fp_log[0], 6);

    // R6 older FP goes; R7 second check stalls
    clr_logs();
    send_grp(4'b0011, 8'h03, 4'b0010, 16'h0021, 4, cyc, ok);
    chk("R6 older fp not held", cyc, 1);
    send_grp(4'b0011, 8'h00, 4'b0010, 16'h0043, 4, cyc, ok);
    chk("R7 second check stalls", ok, 0);
    chk("R7 plain fx proceeds count", fx_n, 2);
    chk("R7 plain fx proceeds tag", fx_log[1], 3);
    res_on(4'd2, 1'b0);
    res_off();
    chk("R7 second check dispatched after resolve", int'(grp_ready_o), 1);
    @(negedge clk); grp_valid_i = 0;
    res_on(4'd4, 1'b0);
    res_off();

    // R8 mismatched resolve ignored
    send_grp(4'b0001, 8'h00, 4'b0001, 16'h0007, 4, cyc, ok);
    send_grp(4'b0001, 8'h03, 4'b0000, 16'h0008, 2, cyc, ok);
    chk("R8 fp held while pending", ok, 0);
    res_on(4'd9, 1'b1);
    chk("R8 mismatched resolve no flush", int'(flush_o), 0);
    res_off();
    chk("R8 pending kept after mismatch", int'(grp_ready_o), 0);
    res_on(4'd7, 1'b0);
    res_off();
    chk("R8 matching resolve frees fp", int'(grp_ready_o), 1);
    @(negedge clk); grp_valid_i = 0;
    res_on(4'd7, 1'b1);
    chk("R8 resolve with nothing pending ignored", int'(flush_o), 0);
    res_off();

    // R10 FP may-except flag ignored
    send_grp(4'b0001, 8'h03, 4'b0001, 16'h0001, 1, cyc, ok);
    send_grp(4'b0001, 8'h03, 4'b0000, 16'h0002, 1, cyc, ok);
    chk("R10 fp flag opens no check", ok, 1);
    tk(3);

    // R9 exception flush coincident with held group
    fx_ready_i = 0; fp_ready_i = 0;
    send_grp(4'b0011, 8'h03, 4'b0010, 16'h0021, 2, cyc, ok);
    chk("R9 setup dispatch", ok, 1);
    @(negedge clk); fx_ready_i = 1;
    @(negedge clk); fx_ready_i = 0;
    send_grp(4'b0111, 8'h30, 4'b0000, 16'h0543, 4, cyc, ok);
    chk("R9 group held before fault", ok, 0);
    res_on(4'd2, 1'b1);
    chk("R9 flush raised", int'(flush_o), 1);
    chk("R9 fault tag", int'(fault_tag_o), 2);
    chk("R9 group discarded", int'(grp_ready_o), 1);
    chk("R9 fx head hidden in flush cycle", int'(fx_valid_o), 0);
    @(negedge clk); res_valid_i = 0; res_exc_i = 0; grp_valid_i = 0; #1;
    chk("R9 fx queue emptied", int'(fx_valid_o), 0);
    chk("R9 fp queue kept", int'(fp_valid_o), 1);
    chk("R9 fp entry tag", int'(fp_tag_o), 1);
    send_grp(4'b0001, 8'h03, 4'b0000, 16'h0006, 1, cyc, ok);
    chk("R9 check closed by flush", ok, 1);

    // R1 mid-run reset with pending and full queue
    send_grp(4'b0001, 8'h00, 4'b0001, 16'h0009, 2, cyc, ok);
    send_grp(4'hF, 8'h00, 4'h0, 16'h3210, 2, cyc, ok);
    @(negedge clk); grp_valid_i = 0; rst_ni = 0;
    tk(2);
    rst_ni = 1; #1;
    chk("R1 fx empty after reset", int'(fx_valid_o), 0);
    chk("R1 fp empty after reset", int'(fp_valid_o), 0);
    send_grp(4'b0001, 8'h03, 4'b0000, 16'h0003, 1, cyc, ok);
    chk("R1 pending cleared by reset", ok, 1);

    tk(2);
    summary();
    $finish;
  end
endmodule